// File: doc/BRIEF.md
# Two-Stage Real-Time-Clock Prescaler

This block divides a slow real-time-clock source, typically 32768 Hz, down to a one-second calendar tick. It uses two cascaded down-counters. The first stage counts every input clock and emits `async_tick` once per `fa+1` clocks. The second stage counts those ticks and emits `sec_tick` once per `fs+1` of them. With the factors at their domain-reset values of 127 and 255, the result is one tick per 32768 clocks.

Software sees four word addresses on a simple write/read port:

| Address | Write | Read |
|---|---|---|
| 0 | key | zero |
| 1 | factors | factors |
| 2 | control | control |
| 3 | shift command | status |

Protection works in two layers. A key state machine (`LK_LOCKED`, `LK_HALF`, `LK_OPEN`) must be opened first. After that, a mode state machine (`MD_RUN`, `MD_INIT`) must be in `MD_INIT` before the factors can be changed.

The key machine moves as follows:
- `LK_LOCKED` or `LK_HALF` goes to `LK_HALF` on a key byte 0xCA.
- `LK_HALF` goes to `LK_OPEN` on a key byte 0x53.
- Any other key write goes to `LK_LOCKED`, as does any non-key write while in `LK_HALF`.
- A key write of 0xCA while in `LK_OPEN` goes to `LK_HALF`.

The mode machine moves to `MD_INIT` or to `MD_RUN` on an unlocked control write.

While in `MD_INIT`, both counters sit at their reload values. A shift command delays the second stage by a programmed number of first-stage ticks. A status flag shows whether reprogramming of the wakeup timer is currently allowed.

Top module: `rtc_prescaler`

## Requirements
- R1: `async_tick` is high for one clock out of every `fa+1` while in `MD_RUN`.
- R2: `sec_tick` is high only together with `async_tick`, once every `fs+1` async ticks.
- R3: The domain reset sets `fa` to 127 and `fs` to 255, so address 1 reads 0x007F00FF. The system reset leaves both factors untouched.
- R4: Key writes go to address 0, and only bits 7:0 are compared. 0xCA followed by 0x53 in consecutive writes opens the lock, shown at status bit 3. Any other key value relocks, and so does any non-key write between the two key bytes.
- R5: Control writes go to address 2 and take effect only when unlocked. Bit 0 requests `MD_INIT`. Bit 1 is the wakeup enable. Status bit 0 shows `MD_INIT`.
- R6: Writes to address 1 take effect only when the block is unlocked and in `MD_INIT`. Write bit 31 selects the field: when it is 1, bits 22:16 load `fa`; when it is 0, bits 14:0 load `fs`. Loading both factors therefore takes two writes.
- R7: Reserved bits read as zero: bits 31:23 and bit 15 of address 1, and everything above the defined bits of addresses 0, 2 and 3. Writes to reserved bits have no effect.
- R8: In `MD_INIT`, both counters hold their reload values and no tick is issued. After the exit, the first `async_tick` comes `fa` clocks after the edge that enters `MD_RUN`.
- R9: A shift write takes bits 14:0 of address 3 as the shift amount. It is accepted only when unlocked, in `MD_RUN` and with no shift pending, and it sets status bit 1.
  - At the next `async_tick`, the second stage's next value becomes its normal next value plus the amount, clipped to `fs`.
  - The pending bit clears on that same edge.
  - Shift writes made while a shift is pending are ignored.
- R10: Status bit 2 (wakeup write allowed) equals, one clock late, "wakeup enable is 0 and not in `MD_INIT`". Its reset value is 1. Status is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time-clock source |
| dom_rst_n | input | 1 | Domain reset, active low, synchronous; resets the factors |
| sys_rst_n | input | 1 | System reset, active low, synchronous; resets the state machines, counters and flags |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| async_tick | output | 1 | First-stage tick |
| sec_tick | output | 1 | Second-stage (one-second) tick |

## Verification
A pending shift and the wrap of the second stage can fall on the same `async_tick`. To provoke this, the bench counts four async ticks after a `sec_tick` and then issues a shift, so that the shift is applied exactly on the tick that wraps the second stage. The judgement is that `sec_tick` still fires on that tick, the pending flag clears, and the counter restarts at `fs` because of the clip.

The bench's behavioural model predicts both ticks and the selected read word on every clock, so any slip after the coincidence also shows up.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
    typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lock_e;
    typedef enum logic {MD_RUN, MD_INIT} mode_e;

    localparam logic [1:0] ADR_KEY = 2'd0;
    localparam logic [1:0] ADR_FAC = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;
    localparam logic [1:0] ADR_SHF = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;
endpackage

// File: rtl/rtc_key_gate.sv
module rtc_key_gate
    import rtc_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_byte,
    output logic       open_o
);
    lock_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en && wr_addr == ADR_KEY) begin
            unique case (state_q)
                LK_LOCKED: state_d = (wr_byte == KEY_FIRST) ? LK_HALF : LK_LOCKED;
                LK_HALF:   state_d = (wr_byte == KEY_FIRST)  ? LK_HALF :
                                     (wr_byte == KEY_SECOND) ? LK_OPEN : LK_LOCKED;
                LK_OPEN:   state_d = (wr_byte == KEY_FIRST) ? LK_HALF : LK_LOCKED;
                default:   state_d = LK_LOCKED;
            endcase
        end else if (wr_en && state_q == LK_HALF) begin
            state_d = LK_LOCKED;
        end
    end

    always_comb begin
        open_o = (state_q == LK_OPEN);
    end

    // R4
    open_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(wr_en && wr_addr == ADR_KEY && wr_byte == KEY_SECOND));

    // R4
    open_held_without_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !(wr_en && wr_addr == ADR_KEY)) |=> open_o);
endmodule

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] reload,
    input  logic         add_en,
    input  logic [W-1:0] add_amt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] base;
    logic [W:0]   sum;

    always_comb begin
        base = (cnt_q == '0) ? reload : cnt_q - 1'b1;
        sum  = {1'b0, base} + {1'b0, add_amt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= reload;
        end else if (step) begin
            if (!add_en)                  cnt_q <= base;
            else if (sum > {1'b0, reload}) cnt_q <= reload;
            else                          cnt_q <= sum[W-1:0];
        end
    end

    assign wrap = !hold && step && (cnt_q == '0);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> cnt_q <= reload);

    // R2
    reload_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !add_en) |=> cnt_q == $past(reload));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_presc_pkg::*;
#(
    parameter int unsigned AW    = 7,
    parameter int unsigned SW    = 15,
    parameter int unsigned A_LSB = 16,
    parameter int unsigned A_RST = 127,
    parameter int unsigned S_RST = 255
) (
    input  logic        clk,
    input  logic        dom_rst_n,
    input  logic        sys_rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        async_tick,
    output logic        sec_tick
);
    localparam int unsigned SEL_BIT = 31;
    localparam logic [31:0] USED_MASK = (32'd1 << SEL_BIT)
                                      | (((32'd1 << AW) - 1) << A_LSB)
                                      | ((32'd1 << SW) - 1);

    logic          open;
    mode_e         mode_q, mode_d;
    logic [AW-1:0] fa_q;
    logic [SW-1:0] fs_q;
    logic          wake_en_q, wake_ok_q;
    logic          pend_q;
    logic [SW-1:0] shamt_q;
    logic          in_init;
    logic          fac_we, ctl_we, shf_we;
    logic          unused_wr;

    assign unused_wr = ^(wr_data & ~USED_MASK);
    assign in_init   = (mode_q == MD_INIT);
    assign fac_we    = wr_en && wr_addr == ADR_FAC && open && in_init;
    assign ctl_we    = wr_en && wr_addr == ADR_CTL && open;
    assign shf_we    = wr_en && wr_addr == ADR_SHF && open && !in_init && !pend_q;

    rtc_key_gate u_key (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_byte (wr_data[7:0]),
        .open_o  (open)
    );

    always_ff @(posedge clk) begin
        if (!sys_rst_n) mode_q <= MD_RUN;
        else            mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MD_RUN:  if (ctl_we && wr_data[0])  mode_d = MD_INIT;
            MD_INIT: if (ctl_we && !wr_data[0]) mode_d = MD_RUN;
            default: mode_d = MD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!dom_rst_n) begin
            fa_q <= AW'(A_RST);
            fs_q <= SW'(S_RST);
        end else if (fac_we) begin
            if (wr_data[SEL_BIT]) fa_q <= wr_data[A_LSB +: AW];
            else                  fs_q <= wr_data[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            wake_en_q <= 1'b0;
            wake_ok_q <= 1'b1;
            pend_q    <= 1'b0;
            shamt_q   <= '0;
        end else begin
            if (ctl_we) wake_en_q <= wr_data[1];
            wake_ok_q <= !wake_en_q && !in_init;
            if (pend_q && async_tick) begin
                pend_q <= 1'b0;
            end else if (shf_we) begin
                pend_q  <= 1'b1;
                shamt_q <= wr_data[SW-1:0];
            end
        end
    end

    rtc_div_stage #(.W(AW)) u_stage_a (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .hold    (in_init),
        .step    (1'b1),
        .reload  (fa_q),
        .add_en  (1'b0),
        .add_amt ('0),
        .wrap    (async_tick)
    );

    rtc_div_stage #(.W(SW)) u_stage_s (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .hold    (in_init),
        .step    (async_tick),
        .reload  (fs_q),
        .add_en  (pend_q),
        .add_amt (shamt_q),
        .wrap    (sec_tick)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_KEY: rd_data = '0;
            ADR_FAC: begin
                rd_data[SW-1:0]       = fs_q;
                rd_data[A_LSB +: AW]  = fa_q;
            end
            ADR_CTL: rd_data[1:0] = {wake_en_q, in_init};
            ADR_SHF: rd_data[3:0] = {open, wake_ok_q, pend_q, in_init};
            default: rd_data = '0;
        endcase
    end

    // R2
    sec_with_async_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        sec_tick |-> async_tick);

    // R9
    shift_clears_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (pend_q && async_tick) |=> !pend_q);

    // R10
    no_wake_in_init_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (in_init && $past(in_init)) |-> !wake_ok_q);

    // R6
    factors_frozen_chk: assert property (@(posedge clk) disable iff (!dom_rst_n || !sys_rst_n)
        !in_init |=> $stable({fa_q, fs_q}));
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
    logic        clk = 1'b0;
    logic        dom_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = 2'd3;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        async_tick, sec_tick;

    int errors = 0, checks = 0;
    bit cmp_on = 0;

    // behavioural model state
    int m_fa = 127, m_fs = 255, m_lock = 0, m_ac = 0, m_sc = 0, m_sh = 0;
    bit m_init = 0, m_wen = 0, m_wok = 1, m_pend = 0;

    rtc_prescaler uut (
        .clk(clk), .dom_rst_n(dom_rst_n), .sys_rst_n(sys_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .async_tick(async_tick), .sec_tick(sec_tick)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(logic [1:0] a);
        case (a)
            2'd1:    return (32'(m_fa) << 16) | 32'(m_fs);
            2'd2:    return {30'd0, m_wen, m_init};
            2'd3:    return {28'd0, m_lock == 2, m_wok, m_pend, m_init};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        int  o_fa, o_fs, o_lock, o_ac, o_sc, o_sh, base;
        bit  o_init, o_wen, o_pend, at;
        o_fa = m_fa; o_fs = m_fs; o_lock = m_lock; o_ac = m_ac; o_sc = m_sc;
        o_sh = m_sh; o_init = m_init; o_wen = m_wen; o_pend = m_pend;
        at = !o_init && o_ac == 0;
        if (!dom_rst_n) begin
            m_fa = 127; m_fs = 255;
        end else if (wr_en && wr_addr == 1 && o_lock == 2 && o_init) begin
            if (wr_data[31]) m_fa = int'(wr_data[22:16]);
            else             m_fs = int'(wr_data[14:0]);
        end
        if (!sys_rst_n) begin
            m_lock = 0; m_init = 0; m_wen = 0; m_wok = 1; m_pend = 0; m_sh = 0;
            m_ac = o_fa; m_sc = o_fs;
        end else begin
            if (wr_en && wr_addr == 0) begin
                if (wr_data[7:0] == 8'hCA) m_lock = 1;
                else if (wr_data[7:0] == 8'h53 && o_lock == 1) m_lock = 2;
                else m_lock = 0;
            end else if (wr_en && o_lock == 1) m_lock = 0;
            if (wr_en && wr_addr == 2 && o_lock == 2) begin
                m_init = wr_data[0]; m_wen = wr_data[1];
            end
            m_wok = !o_wen && !o_init;
            if (o_init)        m_ac = o_fa;
            else if (o_ac == 0) m_ac = o_fa;
            else               m_ac = o_ac - 1;
            if (o_init) m_sc = o_fs;
            else if (at) begin
                base = (o_sc == 0) ? o_fs : o_sc - 1;
                if (o_pend) begin
                    base = base + o_sh;
                    if (base > o_fs) base = o_fs;
                end
                m_sc = base;
            end
            if (at && o_pend) m_pend = 0;
            else if (wr_en && wr_addr == 3 && o_lock == 2 && !o_init && !o_pend) begin
                m_pend = 1; m_sh = int'(wr_data[14:0]);
            end
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            chk("R1 async_tick", 32'(async_tick), 32'(!m_init && m_ac == 0));
            chk("R2 sec_tick", 32'(sec_tick), 32'(!m_init && m_ac == 0 && m_sc == 0));
            chk("R7 read word", rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
        rd_addr = 2'd3;
    endtask

    task automatic wait_async(output int n);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!async_tick);
    endtask

    task automatic wait_sec(output int n);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!sec_tick);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        int seen;
        repeat (3) @(negedge clk);
        dom_rst_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        rd(1, v); chk("R3 reset factors", v, 32'h007F00FF);
        rd(3, v); chk("R10 reset status", v, 32'h4);

        wr(1, 32'h8003_0000);
        rd(1, v); chk("R6 locked factor write ignored", v, 32'h007F00FF);
        wr(2, 32'h1);
        rd(3, v); chk("R5 locked control ignored", v, 32'h4);

        wr(0, 32'hCA); wr(0, 32'h11); wr(0, 32'h53);
        rd(3, v); chk("R4 broken key sequence", v[3], 1'b0);
        wr(0, 32'hCA); wr(0, 32'h53);
        rd(3, v); chk("R4 unlocked", v[3], 1'b1);

        wr(1, 32'h0000_0004);
        rd(1, v); chk("R6 factor write in run ignored", v, 32'h007F00FF);

        wr(2, 32'h1);
        repeat (2) @(negedge clk);
        rd(3, v); chk("R5 R10 init status", v, 32'h9);

        wr(1, 32'h8003_0000);
        wr(1, 32'h0009_0004);
        rd(1, v); chk("R6 two field writes", v, 32'h0003_0004);
        wr(1, 32'h0000_8005);
        rd(1, v); chk("R7 reserved bit 15", v, 32'h0003_0005);
        wr(1, 32'hFF83_0000);
        wr(1, 32'h0000_0004);
        rd(1, v); chk("R7 reserved high bits", v, 32'h0003_0004);

        seen = 0;
        repeat (10) begin @(posedge clk); #1; if (async_tick) seen++; end
        chk("R8 no ticks in init", 32'(seen), 32'd0);

        wr(2, 32'h0);
        wait_async(n); chk("R8 first tick after exit", 32'(n), 32'd3);
        wait_async(n); chk("R1 async period", 32'(n), 32'd4);
        wait_sec(n);
        wait_sec(n);   chk("R2 sec period", 32'(n), 32'd20);

        wr(3, 32'h2);
        rd(3, v); chk("R9 pending set", v[1], 1'b1);
        wr(3, 32'h3);
        wait_async(n);
        @(negedge clk);
        rd(3, v); chk("R9 pending cleared", v[1], 1'b0);

        wait_sec(n);
        repeat (4) wait_async(n);
        wr(3, 32'h7);
        wait_async(n);
        chk("R9 shift on wrapping tick keeps sec_tick", 32'(sec_tick), 32'd1);
        wait_sec(n); chk("R9 period after clipped shift", 32'(n), 32'd20);

        wr(0, 32'hFF);
        rd(3, v); chk("R4 relock", v[3], 1'b0);

        wr(0, 32'hCA); wr(0, 32'h53);
        wr(2, 32'h2);
        repeat (2) @(negedge clk);
        rd(3, v); chk("R10 wake enable blocks", v[2], 1'b0);
        wr(2, 32'h0);
        repeat (2) @(negedge clk);
        rd(3, v); chk("R10 wake allowed again", v[2], 1'b1);

        @(negedge clk); sys_rst_n = 1'b0;
        repeat (2) @(negedge clk); sys_rst_n = 1'b1;
        rd(1, v); chk("R3 system reset keeps factors", v, 32'h0003_0004);
        rd(3, v); chk("R4 system reset locks", v[3], 1'b0);

        @(negedge clk); dom_rst_n = 1'b0;
        repeat (3) @(negedge clk); dom_rst_n = 1'b1;
        rd(1, v); chk("R3 domain reset factors", v, 32'h007F00FF);
        wait_sec(n);
        wait_sec(n); chk("R2 default one second", 32'(n), 32'd32768);

        finish_run();
    end
endmodule